// File: doc/BRIEF.md
# Four-Channel Single-Transfer DMA Controller

This block moves data between peripherals and memory on behalf of a host that programs it through a small byte-wide register window. Each of its four channels keeps a 16-bit current address, a 16-bit remaining-unit count and an 8-bit page byte that supplies the top of a 24-bit memory address. A peripheral raises its request line; the controller grants one channel at a time for a single bus cycle, presents the memory address with a read or write strobe, and then steps that channel's address up and its count down.

Sixteen-bit address and count values pass through the 8-bit data port as two writes. A shared byte pointer steers each write to the low or the high half. Because the page byte is never touched by the address increment, a transfer stays inside one 64 KiB window. A build-time parameter turns an instance into a word-wide controller, in which addresses and counts are given in 16-bit units and the emitted address is doubled.

A channel whose count runs out flags terminal count, masks itself and records the event in a status byte. The host clears these records by reading them.

Top module: `dmac_top`

## Requirements
- R1: Offsets 0–3 hold the address of channels 0–3 and offsets 4–7 hold their count. Each write to one of these offsets loads the low byte when the shared byte pointer is 0 and the high byte when it is 1, then toggles the pointer.
- R2: Any write to offset 14 returns the byte pointer to 0, whatever the data byte holds.
- R3: A count programmed as N−1 yields exactly N granted units before the channel stops.
- R4: A write to offset 12 sets the mode of the channel named by data bits [1:0]. A channel is serviced only when bits [7:6] are 01 and bits [3:2] are 01 or 10. Code 01 drives `mem_wr` during the unit and code 10 drives `mem_rd`. The two strobes are never high together, and one of them is high exactly when a grant is given.
- R5: During a unit, `mem_addr` equals the page byte in bits [23:16] and the channel address shifted left by SHIFT, truncated to 16 bits, in bits [15:0]. After each unit the address goes up by one and wraps from FFFF to 0000 without altering the page.
- R6: A write to offset 13 selects a channel with data bits [1:0]. Bit 2 = 1 masks the channel and bit 2 = 0 unmasks it. A masked channel receives no new grant.
- R7: A grant lasts exactly one cycle, is one-hot, and is followed by at least one cycle without a grant. Among eligible channels, the lowest index wins.
- R8: `tc` is high during the unit that finds the count at zero. That unit sets the channel's status bit and masks the channel.
- R9: A read at offset 12 returns the terminal-count bits in [3:0] and the live request lines in [7:4], and clears the terminal-count bits it returned. A bit set by a unit ending in the same cycle survives the read.
- R10: A write to offset 15 zeroes every address, count, page and mode, clears the byte pointer and status, masks all channels, and cancels any unit in progress.
- R11: If a write that unmasks a channel lands in the same cycle as that channel's terminal-count unit, the channel ends up masked.
- R12: After reset, all channels are masked, no grant or strobe is active, and the status byte reads with zero terminal-count bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | Register write strobe |
| io_rd | input | 1 | Register read strobe |
| io_addr | input | 4 | Register offset |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (status at offset 12, otherwise 0) |
| dreq | input | 4 | Per-channel transfer request |
| dack | output | 4 | Per-channel grant, one unit cycle |
| mem_addr | output | 24 | Memory address during a unit |
| mem_rd | output | 1 | Memory read strobe (memory to device) |
| mem_wr | output | 1 | Memory write strobe (device to memory) |
| tc | output | 1 | Terminal count, high in a channel's last unit |

## Verification
Two events can meet in the cycle where a channel finishes its last unit. The terminal-count bit can be set in that cycle while a host read of status clears the bits, or the channel can mask itself while a host write unmasks it. The bench waits until it sees the grant that carries `tc`. It then places the status read, or in a separate run the unmask write, in that exact cycle. For the read, it checks that the value returned does not yet show the bit and that the next read does. For the unmask, it holds the request high for ten more cycles and checks that no further grant appears.

// File: rtl/dmac_pkg.sv
// Package: shared widths, register offsets and field codes for the DMA block.
// Assumes four channels, which is fixed by the two-bit channel field of the
// mode and mask registers.
package dmac_pkg;
    localparam int NCH = 4;
    localparam int CHW = $clog2(NCH);
    localparam int AW  = 16;
    localparam int PW  = 8;
    localparam int MAW = AW + PW;

    localparam logic [3:0] OFF_MODE   = 4'd12;  // write: mode, read: status
    localparam logic [3:0] OFF_MASK   = 4'd13;
    localparam logic [3:0] OFF_CLRPTR = 4'd14;
    localparam logic [3:0] OFF_MCLR   = 4'd15;

    localparam logic [1:0] GRP_ADDR = 2'b00;
    localparam logic [1:0] GRP_CNT  = 2'b01;
    localparam logic [1:0] GRP_PAGE = 2'b10;

    localparam logic [1:0] DIR_TOMEM   = 2'b01;
    localparam logic [1:0] DIR_FROMMEM = 2'b10;
    localparam logic [1:0] KIND_SINGLE = 2'b01;

    typedef struct packed {
        logic [1:0] kind;
        logic [1:0] dir;
    } chan_mode_t;
endpackage

// File: rtl/dmac_chan.sv
// Module: one DMA channel's register set and datapath.
// Holds address, count, page, mode and mask. Steps the address up and the
// count down on each granted unit. Assumes at most one host write per cycle.
// Host byte writes override the stepped byte, and the self-mask on terminal
// count overrides a host unmask.
module dmac_chan
    import dmac_pkg::*;
#(
    parameter int SHIFT = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mclr,
    input  logic           wr_addr,
    input  logic           wr_cnt,
    input  logic           wr_page,
    input  logic           wr_mode,
    input  logic           wr_mask,
    input  logic           hi_byte,
    input  logic [7:0]     wdata,
    input  logic           step,
    input  logic           dreq,
    output logic           req,
    output logic           last,
    output logic [1:0]     dir,
    output logic [MAW-1:0] maddr
);
    logic [AW-1:0] addr_q, cnt_q, addr_sh;
    logic [PW-1:0] page_q;
    chan_mode_t    mode_q;
    logic          masked_q;

    // Register update: the stepped datapath first, host writes over it, self-mask last.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            addr_q   <= '0;
            cnt_q    <= '0;
            page_q   <= '0;
            mode_q   <= '0;
            masked_q <= 1'b1;
        end else begin
            if (step) begin
                addr_q <= addr_q + 1'b1;
                cnt_q  <= cnt_q - 1'b1;
            end
            if (wr_addr) begin
                if (hi_byte) addr_q[15:8] <= wdata;
                else         addr_q[7:0]  <= wdata;
            end
            if (wr_cnt) begin
                if (hi_byte) cnt_q[15:8] <= wdata;
                else         cnt_q[7:0]  <= wdata;
            end
            if (wr_page) page_q <= wdata;
            if (wr_mode) mode_q <= '{kind: wdata[7:6], dir: wdata[3:2]};
            if (wr_mask) masked_q <= wdata[2];
            if (step && cnt_q == '0) masked_q <= 1'b1;
        end
    end

    // Eligibility and address formation.
    always_comb begin
        req     = dreq && !masked_q && mode_q.kind == KIND_SINGLE &&
                  (mode_q.dir == DIR_TOMEM || mode_q.dir == DIR_FROMMEM);
        last    = (cnt_q == '0);
        dir     = mode_q.dir;
        addr_sh = addr_q << SHIFT;
        maddr   = {page_q, addr_sh};
    end
endmodule

// File: rtl/dmac_arb.sv
// Module: fixed-priority arbiter. The lowest-numbered requesting channel wins.
// Purely combinational. Assumes the caller samples it only while idle.
module dmac_arb
    import dmac_pkg::*;
(
    input  logic [NCH-1:0] req,
    output logic           any,
    output logic [CHW-1:0] idx
);
    // Scan from the highest index down so the lowest one is written last.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) idx = CHW'(i);
        end
    end
endmodule

// File: rtl/dmac_xfer.sv
// Module: unit sequencer for single-transfer mode. Idles one cycle to
// arbitrate, then holds a grant for exactly one cycle and releases.
// Assumes master clear cancels any unit in progress.
module dmac_xfer
    import dmac_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mclr,
    input  logic           any,
    input  logic [CHW-1:0] idx,
    output logic           busy,
    output logic [CHW-1:0] gnt
);
    // Alternate between an arbitration cycle and a one-cycle unit.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            busy <= 1'b0;
            gnt  <= '0;
        end else if (busy) begin
            busy <= 1'b0;
        end else if (any) begin
            busy <= 1'b1;
            gnt  <= idx;
        end
    end
endmodule

// File: rtl/dmac_top.sv
// Module: four-channel single-transfer DMA controller top.
// Decodes the byte-wide register window, owns the shared byte pointer and the
// status bits, and muxes the granted channel onto the memory side.
// Assumes one host access (read or write) per cycle.
module dmac_top
    import dmac_pkg::*;
#(
    parameter int SHIFT = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           io_wr,
    input  logic           io_rd,
    input  logic [3:0]     io_addr,
    input  logic [7:0]     io_wdata,
    output logic [7:0]     io_rdata,
    input  logic [NCH-1:0] dreq,
    output logic [NCH-1:0] dack,
    output logic [MAW-1:0] mem_addr,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic           tc
);
    logic           mclr, clr_ptr, rd_stat, ptr_q, ptr_hit;
    logic           busy, any;
    logic [CHW-1:0] gnt, win;
    logic [NCH-1:0] ch_req, ch_last, tc_set, tc_q;
    logic [1:0]     ch_dir   [NCH];
    logic [MAW-1:0] ch_maddr [NCH];

    // Shared-register decode.
    always_comb begin
        mclr    = io_wr && io_addr == OFF_MCLR;
        clr_ptr = io_wr && io_addr == OFF_CLRPTR;
        rd_stat = io_rd && io_addr == OFF_MODE;
        ptr_hit = io_wr && (io_addr[3:2] == GRP_ADDR || io_addr[3:2] == GRP_CNT);
    end

    // Byte pointer: toggles on each address/count byte, cleared by strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr || clr_ptr) ptr_q <= 1'b0;
        else if (ptr_hit)              ptr_q <= ~ptr_q;
    end

    // One unit strobe per granted channel.
    assign dack   = busy ? (NCH'(1) << gnt) : '0;
    assign tc_set = dack & ch_last;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dmac_chan #(.SHIFT(SHIFT)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .mclr    (mclr),
            .wr_addr (io_wr && io_addr[3:2] == GRP_ADDR && io_addr[1:0] == CHW'(i)),
            .wr_cnt  (io_wr && io_addr[3:2] == GRP_CNT  && io_addr[1:0] == CHW'(i)),
            .wr_page (io_wr && io_addr[3:2] == GRP_PAGE && io_addr[1:0] == CHW'(i)),
            .wr_mode (io_wr && io_addr == OFF_MODE && io_wdata[1:0] == CHW'(i)),
            .wr_mask (io_wr && io_addr == OFF_MASK && io_wdata[1:0] == CHW'(i)),
            .hi_byte (ptr_q),
            .wdata   (io_wdata),
            .step    (dack[i]),
            .dreq    (dreq[i]),
            .req     (ch_req[i]),
            .last    (ch_last[i]),
            .dir     (ch_dir[i]),
            .maddr   (ch_maddr[i])
        );
    end

    dmac_arb u_arb (
        .req (ch_req),
        .any (any),
        .idx (win)
    );

    dmac_xfer u_xfer (
        .clk   (clk),
        .rst_n (rst_n),
        .mclr  (mclr),
        .any   (any),
        .idx   (win),
        .busy  (busy),
        .gnt   (gnt)
    );

    // Status bits: a read clears what it returns, a fresh set survives.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) tc_q <= '0;
        else                tc_q <= (rd_stat ? '0 : tc_q) | tc_set;
    end

    // Memory-side outputs and read data.
    always_comb begin
        mem_addr = busy ? ch_maddr[gnt] : '0;
        mem_wr   = busy && ch_dir[gnt] == DIR_TOMEM;
        mem_rd   = busy && ch_dir[gnt] == DIR_FROMMEM;
        tc       = |tc_set;
        io_rdata = rd_stat ? {dreq, tc_q} : 8'h00;
    end
endmodule

// File: rtl/dmac_checker.sv
// Module: protocol checker for dmac_top, attached by bind. Observes ports only.
module dmac_checker
    import dmac_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           io_wr,
    input logic           io_rd,
    input logic [3:0]     io_addr,
    input logic [7:0]     io_rdata,
    input logic [NCH-1:0] dreq,
    input logic [NCH-1:0] dack,
    input logic           mem_rd,
    input logic           mem_wr,
    input logic           tc
);
    assert_dack_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack));

    assert_dack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dack != '0) |=> (dack == '0));

    assert_tc_in_unit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (dack != '0));

    assert_tc_selfmask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> ##1 ((dack & $past(dack, 2)) == '0));

    assert_dir_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_strobe_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dack != '0) == (mem_rd || mem_wr));

    assert_mclr_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == OFF_MCLR) |=> (dack == '0));

    assert_status_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == OFF_MODE) |-> (io_rdata[7:4] == dreq));

    assert_reset_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dack == '0 && !tc));
endmodule

bind dmac_top dmac_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_addr  (io_addr),
    .io_rdata (io_rdata),
    .dreq     (dreq),
    .dack     (dack),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .tc       (tc)
);

// File: tb/dmac_top_bench.sv
// Bench: behavioural reference model run in lockstep with dmac_top (word mode),
// compared every cycle, plus directed checks per requirement.
module dmac_top_bench;
    localparam int SH = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [3:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [3:0]  dreq = '0, dack;
    logic [23:0] mem_addr;
    logic        mem_rd, mem_wr, tc;

    always #2 clk = ~clk;

    dmac_top #(.SHIFT(SH)) u_dmac_top (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .dreq(dreq), .dack(dack),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .tc(tc)
    );

    // Reference model state.
    logic [15:0] m_addr [4];
    logic [15:0] m_cnt  [4];
    logic [7:0]  m_page [4];
    logic [7:0]  m_mode [4];
    logic [3:0]  m_mask, m_tc;
    logic        m_ptr, m_busy;
    int          m_gnt;

    int checks = 0, fails = 0;
    int ack_cnt [4];
    int tc_cnt = 0;
    logic [23:0] alog [$];
    int          gq [$];
    bit          done = 0;

    function automatic void m_clear();
        for (int i = 0; i < 4; i++) begin
            m_addr[i] = '0; m_cnt[i] = '0; m_page[i] = '0; m_mode[i] = '0;
        end
        m_mask = 4'hF; m_tc = '0; m_ptr = 0; m_busy = 0; m_gnt = 0;
    endfunction

    function automatic bit m_ok(int i);
        return !m_mask[i] && dreq[i] && m_mode[i][7:6] == 2'b01 &&
               (m_mode[i][3:2] == 2'b01 || m_mode[i][3:2] == 2'b10);
    endfunction

    // Model clock step, from the requirements.
    always @(posedge clk) begin
        if (!rst_n || (io_wr && io_addr == 4'd15)) m_clear();
        else begin
            automatic bit   ostep = m_busy;
            automatic int   g = m_gnt, w = -1;
            automatic logic [3:0] tset = '0;
            for (int i = 3; i >= 0; i--) if (m_ok(i)) w = i;
            if (ostep) begin
                m_addr[g] = m_addr[g] + 16'd1;
                if (m_cnt[g] == 0) tset[g] = 1'b1;
                m_cnt[g] = m_cnt[g] - 16'd1;
            end
            if (io_wr) begin
                automatic int c = int'(io_addr[1:0]);
                automatic int d = int'(io_wdata[1:0]);
                if (io_addr < 4) begin
                    if (m_ptr) m_addr[c][15:8] = io_wdata; else m_addr[c][7:0] = io_wdata;
                    m_ptr = !m_ptr;
                end else if (io_addr < 8) begin
                    if (m_ptr) m_cnt[c][15:8] = io_wdata; else m_cnt[c][7:0] = io_wdata;
                    m_ptr = !m_ptr;
                end else if (io_addr < 12) m_page[c] = io_wdata;
                else if (io_addr == 12) m_mode[d] = io_wdata;
                else if (io_addr == 13) m_mask[d] = io_wdata[2];
                else if (io_addr == 14) m_ptr = 0;
            end
            m_mask = m_mask | tset;
            m_tc = ((io_rd && io_addr == 4'd12) ? 4'h0 : m_tc) | tset;
            if (ostep) m_busy = 0;
            else if (w >= 0) begin m_busy = 1; m_gnt = w; end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, at the falling edge.
    task automatic cmp_all();
        logic [3:0]  edack = m_busy ? (4'd1 << m_gnt) : 4'd0;
        logic [15:0] sh = m_addr[m_gnt] << SH;
        logic [1:0]  d = m_mode[m_gnt][3:2];
        chk("R7 dack", dack, edack);
        chk("R5 mem_addr", mem_addr, m_busy ? {m_page[m_gnt], sh} : 24'h0);
        chk("R4 strobes", {mem_rd, mem_wr}, m_busy ? {d == 2'b10, d == 2'b01} : 2'b00);
        chk("R8 tc", tc, m_busy && m_cnt[m_gnt] == 0);
        chk("R9 rdata", io_rdata, (io_rd && io_addr == 12) ? {dreq, m_tc} : 8'h00);
        for (int i = 0; i < 4; i++) if (dack[i]) begin ack_cnt[i]++; gq.push_back(i); end
        if (dack != 0) alog.push_back(mem_addr);
        if (tc) tc_cnt++;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cmp_all();
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        io_wr = 1; io_addr = a; io_wdata = d;
        tick();
        io_wr = 0;
    endtask

    task automatic rd_status(output logic [7:0] v);
        io_rd = 1; io_addr = 4'd12;
        #1 v = io_rdata;
        tick();
        io_rd = 0;
    endtask

    task automatic prog(input int ch, input logic [15:0] a, input logic [15:0] n,
                        input logic [7:0] pg, input logic [7:0] mode);
        wr(4'd14, 8'h00);
        wr(4'(ch), a[7:0]);     wr(4'(ch), a[15:8]);
        wr(4'(4 + ch), n[7:0]); wr(4'(4 + ch), n[15:8]);
        wr(4'(8 + ch), pg);
        wr(4'd12, mode);
    endtask

    task automatic wait_ack(input int ch);
        for (int k = 0; k < 20; k++) begin
            if (dack[ch]) break;
            tick();
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n;
        for (int i = 0; i < 4; i++) ack_cnt[i] = 0;
        m_clear();
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        // R12: reset state
        rd_status(v);
        chk("R12 status after reset", v, 8'h00);
        chk("R12 dack after reset", dack, 4'h0);

        // R1/R2/R3/R5: ch1, word mode, stray low byte then pointer clear with data FF
        wr(4'd14, 8'h00);
        wr(4'd1, 8'hAA);
        wr(4'd14, 8'hFF);
        wr(4'd1, 8'hFE); wr(4'd1, 8'hFF);
        wr(4'd5, 8'h02); wr(4'd5, 8'h00);
        wr(4'd9, 8'h12);
        wr(4'd12, 8'h45);
        wr(4'd13, 8'h01);
        alog.delete(); tc_cnt = 0;
        dreq = 4'b0010;
        repeat (20) tick();
        dreq = 0;
        tick();
        chk("R3 ch1 unit count", ack_cnt[1], 3);
        chk("R8 one tc pulse", tc_cnt, 1);
        chk("R1 R2 first address", alog.size() > 0 ? alog[0] : 24'hx, 24'h12FFFC);
        chk("R5 wrapped address", alog.size() > 2 ? alog[2] : 24'hx, 24'h120000);
        rd_status(v);
        chk("R8 status tc bit", v, 8'h02);
        rd_status(v);
        chk("R9 cleared after read", v, 8'h00);

        // R7: priority between ch0 and ch2
        prog(0, 16'h0100, 16'd1, 8'h00, 8'h44);
        prog(2, 16'h0200, 16'd1, 8'h00, 8'h46);
        wr(4'd13, 8'h00); wr(4'd13, 8'h02);
        gq.delete();
        dreq = 4'b0101;
        repeat (20) tick();
        dreq = 0;
        chk("R7 grant count", gq.size(), 4);
        chk("R7 first grant", gq.size() > 3 ? gq[0] : -1, 0);
        chk("R7 second grant", gq.size() > 3 ? gq[1] : -1, 0);
        chk("R7 third grant", gq.size() > 3 ? gq[2] : -1, 2);

        // R4: invalid mode never serviced, then read-from-memory mode
        prog(3, 16'h0000, 16'd0, 8'h40, 8'h0B);
        wr(4'd13, 8'h03);
        dreq = 4'b1000;
        repeat (10) tick();
        chk("R4 invalid mode ignored", ack_cnt[3], 0);
        wr(4'd12, 8'h4B);
        repeat (10) tick();
        chk("R4 read mode serviced", ack_cnt[3], 1);
        dreq = 0;
        rd_status(v);

        // R6: mask during activity stops grants, unmask resumes
        prog(2, 16'h0300, 16'd5, 8'h01, 8'h46);
        wr(4'd13, 8'h02);
        dreq = 4'b0100;
        n = ack_cnt[2];
        wait_ack(2);
        wr(4'd13, 8'h06);
        chk("R6 one unit before mask", ack_cnt[2], n + 1);
        n = ack_cnt[2];
        repeat (10) tick();
        chk("R6 masked no grant", ack_cnt[2], n);
        wr(4'd13, 8'h02);
        repeat (6) tick();
        chk("R6 unmask resumes", ack_cnt[2] > n, 1);
        dreq = 0;
        tick(); tick();
        rd_status(v);

        // R9: status read in the very cycle a terminal count is set
        prog(0, 16'h0400, 16'd0, 8'h00, 8'h44);
        wr(4'd13, 8'h00);
        dreq = 4'b0001;
        wait_ack(0);
        chk("R9 tc visible in unit", tc, 1);
        rd_status(v);
        chk("R9 same-cycle read sees old bits", v[3:0], 4'h0);
        dreq = 0;
        rd_status(v);
        chk("R9 set survives read", v[3:0], 4'h1);

        // R11: unmask landing in the terminal-count cycle
        prog(0, 16'h0500, 16'd0, 8'h00, 8'h44);
        wr(4'd13, 8'h00);
        dreq = 4'b0001;
        wait_ack(0);
        wr(4'd13, 8'h00);
        n = ack_cnt[0];
        repeat (10) tick();
        chk("R11 self-mask wins", ack_cnt[0], n);
        dreq = 0;
        rd_status(v);

        // R10: master clear mid-transfer
        prog(1, 16'h0000, 16'd10, 8'h22, 8'h45);
        wr(4'd13, 8'h01);
        dreq = 4'b0010;
        repeat (5) tick();
        wr(4'd15, 8'h00);
        n = ack_cnt[1];
        repeat (10) tick();
        chk("R10 grants stop", ack_cnt[1], n);
        wr(4'd13, 8'h01);
        repeat (10) tick();
        chk("R10 mode cleared", ack_cnt[1], n);
        rd_status(v);
        chk("R10 status cleared", v, 8'h20);
        dreq = 0;
        tick();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule